// File: doc/BRIEF.md
# Deep Clock-Stop Sleep Controller

This block decides when a microcontroller drops into a deep clock-stop sleep and when it comes back out. Software arms the mode with an enable bit and fills the module-stop masks with the required patterns, then issues a sleep strobe. If the masks qualify, the controller waits for the current bus cycle to finish and then shuts off the peripheral, bus-controller and I/O-port clocks. The watchdog keeps its clock, and the 8-bit timer keeps or loses its clock depending on one mask bit. If the masks do not qualify, the same strobe gives an ordinary sleep in which every clock keeps running.

The controller leaves either sleep state when a qualified wake event arrives: NMI, one of sixteen external interrupt lines, the 8-bit timer or the watchdog. It then sends a one-cycle request to the CPU exception logic. A non-NMI source counts only if interrupts are globally enabled, the CPU priority mask lets it through, and the source is not routed to the data-transfer controller. The reset pin brings the controller back to the run state. A low level on the hardware-standby pin overrides everything else and stops every clock.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `rstPinN` is low and `stbyPinN` is high, the next clock edge puts the controller in run state with all six clock enables at 1 and `wakeReq` at 0, whatever the other inputs are.
- R2: Clock-stop entry is eligible only when `clkStopEn` is 1, `modStopMask` is 16'hFFFF or 16'hFFFE, and `extStopMask` is 16'hFFFF.
- R3: An eligible sleep strobe does not change any output at the next edge. The controller enters clock-stop at the first edge where `busCycleDone` is 1, counting from the cycle after the strobe.
- R4: In clock-stop, `periphClkEn`, `busClkEn` and `ioClkEn` are 0, `wdtClkEn` is 1 and `inClkStop` is 1.
- R5: In clock-stop, `tmrClkEn` equals the inverse of `modStopMask[0]` as sampled on the strobe cycle (1 for 16'hFFFE, 0 for 16'hFFFF).
- R6: In clock-stop, `auxClkEn` is 0 when `auxStopMask` was 16'hFFFF on the strobe cycle, and 1 otherwise.
- R7: A sleep strobe with `swStandby` at 0 that is not eligible gives ordinary sleep at the next edge: `inSleep` is 1 and all clock enables stay 1.
- R8: A sleep strobe while `swStandby` is 1 is ignored, and the controller stays in run.
- R9: Wake sources are `nmiIn` and `wakeSrc`, where bits 0 to 15 are the external IRQ lines, bit 16 is the 8-bit timer and bit 17 is the watchdog. A qualified wake in clock-stop or sleep returns the controller to run at the next edge, restores all enables, and raises `wakeReq` for exactly one cycle.
- R10: A `wakeSrc` bit is ignored when `intDisable` is 1, when `cpuMaskAll` is 1, or when the matching `xferRoute` bit is 1. `nmiIn` wakes regardless of these.
- R11: A qualified wake while entry is pending cancels the entry. The controller stays in run, no `wakeReq` is raised, and a later `busCycleDone` has no effect.
- R12: While `stbyPinN` is low, the next edge puts the controller in hardware standby with all clock enables at 0, even if `rstPinN` is low. It leaves hardware standby only when `rstPinN` is low with `stbyPinN` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rstPinN | input | 1 | Reset pin, active low, sampled on the clock |
| stbyPinN | input | 1 | Hardware-standby pin, active low |
| sleepStb | input | 1 | One-cycle sleep instruction strobe |
| swStandby | input | 1 | Software standby control bit |
| clkStopEn | input | 1 | Clock-stop enable control bit |
| modStopMask | input | 16 | First module-stop mask |
| extStopMask | input | 16 | Extended module-stop mask |
| auxStopMask | input | 16 | Mask of the extra module clock group |
| busCycleDone | input | 1 | Current bus cycle ends this cycle |
| nmiIn | input | 1 | Non-maskable interrupt |
| wakeSrc | input | 18 | IRQ0-15, timer (16), watchdog (17) requests |
| xferRoute | input | 18 | Per-source routing to the transfer controller |
| intDisable | input | 1 | Interrupts globally disabled |
| cpuMaskAll | input | 1 | CPU mask blocks every non-NMI interrupt |
| periphClkEn | output | 1 | Peripheral clock enable |
| busClkEn | output | 1 | Bus-controller clock enable |
| ioClkEn | output | 1 | I/O-port clock enable |
| tmrClkEn | output | 1 | 8-bit timer clock enable |
| wdtClkEn | output | 1 | Watchdog clock enable |
| auxClkEn | output | 1 | Extra module group clock enable |
| wakeReq | output | 1 | One-cycle wake request to exception logic |
| inSleep | output | 1 | Ordinary sleep state |
| inClkStop | output | 1 | Clock-stop state |
| inHwStby | output | 1 | Hardware standby state |

## Verification
A wrong state register shows at the ports one edge later, because the state flags and the registered clock enables move together. Entering clock-stop too early shows up as dropped enables on the cycle right after the strobe. A lost pending state shows up as enables that never drop after `busCycleDone`. A wake qualification error shows up either as a one-cycle `wakeReq` with restored enables on the next edge, or as enables that fail to come back. The scoreboard compares every output on every cycle, so each of these faults is reported on the first cycle it appears.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_PEND   = 3'd1,
    ST_CSTOP  = 3'd2,
    ST_SLEEP  = 3'd3,
    ST_HWSTBY = 3'd4
  } pmState_t;

  typedef struct packed {
    logic toRun;
    logic toSleep;
    logic toStop;
    logic toStby;
    logic wakePulse;
    logic latchCfg;
  } ctrlStb_t;
endpackage

// File: rtl/clkstop_fsm.sv
module clkstop_fsm
  import clkstop_pkg::*;
#(
  parameter int MASK_W  = 16,
  parameter int NUM_IRQ = 16
) (
  input  logic                     clk,
  input  logic                     rstPinN,
  input  logic                     stbyPinN,
  input  logic                     sleepStb,
  input  logic                     swStandby,
  input  logic                     clkStopEn,
  input  logic [MASK_W-1:0]        modStopMask,
  input  logic [MASK_W-1:0]        extStopMask,
  input  logic                     busCycleDone,
  input  logic                     nmiIn,
  input  logic [NUM_IRQ+1:0]       wakeSrc,
  input  logic [NUM_IRQ+1:0]       xferRoute,
  input  logic                     intDisable,
  input  logic                     cpuMaskAll,
  output pmState_t                 stateQ,
  output ctrlStb_t                 stb
);
  localparam int NSRC = NUM_IRQ + 2;
  localparam logic [MASK_W-1:0] ALL_ONES  = {MASK_W{1'b1}};
  localparam logic [MASK_W-1:0] KEEP_TMR  = {{(MASK_W-1){1'b1}}, 1'b0};

  logic [NSRC-1:0] srcOk;
  logic            maskedWake;
  logic            wakeOk;
  logic            eligible;
  pmState_t        stateD;

  // Per-source routing filter: a source sent to the transfer controller cannot wake.
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign srcOk[i] = wakeSrc[i] & ~xferRoute[i];
  end

  assign maskedWake = (|srcOk) & ~intDisable & ~cpuMaskAll;
  assign wakeOk     = nmiIn | maskedWake;
  assign eligible   = clkStopEn && (extStopMask == ALL_ONES) &&
                      ((modStopMask == ALL_ONES) || (modStopMask == KEEP_TMR));

  always_comb begin
    stateD = stateQ;
    stb    = '0;
    if (!stbyPinN) begin
      stateD     = ST_HWSTBY;
      stb.toStby = 1'b1;
    end else if (!rstPinN) begin
      stateD    = ST_RUN;
      stb.toRun = 1'b1;
    end else begin
      unique case (stateQ)
        ST_RUN: begin
          if (sleepStb && !swStandby) begin
            stb.latchCfg = 1'b1;
            if (eligible) begin
              stateD = ST_PEND;
            end else begin
              stateD      = ST_SLEEP;
              stb.toSleep = 1'b1;
            end
          end
        end
        ST_PEND: begin
          if (wakeOk) begin
            stateD    = ST_RUN;
            stb.toRun = 1'b1;
          end else if (busCycleDone) begin
            stateD     = ST_CSTOP;
            stb.toStop = 1'b1;
          end
        end
        ST_CSTOP, ST_SLEEP: begin
          if (wakeOk) begin
            stateD        = ST_RUN;
            stb.toRun     = 1'b1;
            stb.wakePulse = 1'b1;
          end
        end
        ST_HWSTBY: stateD = ST_HWSTBY;
        default: begin
          stateD    = ST_RUN;
          stb.toRun = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    stateQ <= stateD;
  end

  // R3: the strobe cycle itself never lands in clock-stop
  assert_defer_entry_R3: assert property (@(posedge clk) disable iff (!rstPinN)
    (stateQ == ST_RUN && sleepStb && stbyPinN) |=> (stateQ != ST_CSTOP));

  // R8: strobe with software standby set leaves the controller in run
  assert_swstby_ignored_R8: assert property (@(posedge clk) disable iff (!rstPinN)
    (stateQ == ST_RUN && swStandby && stbyPinN) |=> (stateQ == ST_RUN));

  // R10: masked non-NMI requests keep clock-stop in place
  assert_masked_hold_R10: assert property (@(posedge clk) disable iff (!rstPinN)
    (stateQ == ST_CSTOP && stbyPinN && !nmiIn && (intDisable || cpuMaskAll))
    |=> (stateQ == ST_CSTOP));

  // R12: standby pin wins from any state
  assert_hwstby_R12: assert property (@(posedge clk) disable iff (!rstPinN)
    (!stbyPinN) |=> (stateQ == ST_HWSTBY));
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate
  import clkstop_pkg::*;
#(
  parameter int MASK_W = 16
) (
  input  logic              clk,
  input  ctrlStb_t          stb,
  input  logic [MASK_W-1:0] modStopMask,
  input  logic [MASK_W-1:0] auxStopMask,
  output logic              periphClkEn,
  output logic              busClkEn,
  output logic              ioClkEn,
  output logic              tmrClkEn,
  output logic              wdtClkEn,
  output logic              auxClkEn,
  output logic              wakeReq
);
  logic tmrKeepQ;
  logic auxStopQ;

  // Configuration captured on the strobe cycle, applied when entry completes.
  always_ff @(posedge clk) begin
    if (stb.latchCfg) begin
      tmrKeepQ <= ~modStopMask[0];
      auxStopQ <= &auxStopMask;
    end
  end

  always_ff @(posedge clk) begin
    wakeReq <= stb.wakePulse;
    if (stb.toStby) begin
      periphClkEn <= 1'b0;
      busClkEn    <= 1'b0;
      ioClkEn     <= 1'b0;
      tmrClkEn    <= 1'b0;
      wdtClkEn    <= 1'b0;
      auxClkEn    <= 1'b0;
    end else if (stb.toStop) begin
      periphClkEn <= 1'b0;
      busClkEn    <= 1'b0;
      ioClkEn     <= 1'b0;
      tmrClkEn    <= tmrKeepQ;
      wdtClkEn    <= 1'b1;
      auxClkEn    <= ~auxStopQ;
    end else if (stb.toRun || stb.toSleep) begin
      periphClkEn <= 1'b1;
      busClkEn    <= 1'b1;
      ioClkEn     <= 1'b1;
      tmrClkEn    <= 1'b1;
      wdtClkEn    <= 1'b1;
      auxClkEn    <= 1'b1;
    end
  end
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int MASK_W  = 16,
  parameter int NUM_IRQ = 16
) (
  input  logic               clk,
  input  logic               rstPinN,
  input  logic               stbyPinN,
  input  logic               sleepStb,
  input  logic               swStandby,
  input  logic               clkStopEn,
  input  logic [MASK_W-1:0]  modStopMask,
  input  logic [MASK_W-1:0]  extStopMask,
  input  logic [MASK_W-1:0]  auxStopMask,
  input  logic               busCycleDone,
  input  logic               nmiIn,
  input  logic [NUM_IRQ+1:0] wakeSrc,
  input  logic [NUM_IRQ+1:0] xferRoute,
  input  logic               intDisable,
  input  logic               cpuMaskAll,
  output logic               periphClkEn,
  output logic               busClkEn,
  output logic               ioClkEn,
  output logic               tmrClkEn,
  output logic               wdtClkEn,
  output logic               auxClkEn,
  output logic               wakeReq,
  output logic               inSleep,
  output logic               inClkStop,
  output logic               inHwStby
);
  pmState_t stateQ;
  ctrlStb_t stb;

  clkstop_fsm #(.MASK_W(MASK_W), .NUM_IRQ(NUM_IRQ)) u_fsm (
    .clk(clk), .rstPinN(rstPinN), .stbyPinN(stbyPinN), .sleepStb(sleepStb),
    .swStandby(swStandby), .clkStopEn(clkStopEn), .modStopMask(modStopMask),
    .extStopMask(extStopMask), .busCycleDone(busCycleDone), .nmiIn(nmiIn),
    .wakeSrc(wakeSrc), .xferRoute(xferRoute), .intDisable(intDisable),
    .cpuMaskAll(cpuMaskAll), .stateQ(stateQ), .stb(stb)
  );

  clkstop_gate #(.MASK_W(MASK_W)) u_gate (
    .clk(clk), .stb(stb), .modStopMask(modStopMask), .auxStopMask(auxStopMask),
    .periphClkEn(periphClkEn), .busClkEn(busClkEn), .ioClkEn(ioClkEn),
    .tmrClkEn(tmrClkEn), .wdtClkEn(wdtClkEn), .auxClkEn(auxClkEn),
    .wakeReq(wakeReq)
  );

  assign inSleep   = (stateQ == ST_SLEEP);
  assign inClkStop = (stateQ == ST_CSTOP);
  assign inHwStby  = (stateQ == ST_HWSTBY);

  // R4: state flag from the control side agrees with the datapath enables
  assert_gated_in_stop_R4: assert property (@(posedge clk) disable iff (!rstPinN)
    inClkStop |-> (!periphClkEn && !busClkEn && !ioClkEn && wdtClkEn));

  // R12: standby state means every enable is off
  assert_stby_all_off_R12: assert property (@(posedge clk) disable iff (!rstPinN)
    inHwStby |-> !(periphClkEn || busClkEn || ioClkEn || tmrClkEn || wdtClkEn || auxClkEn));

  // R9: wake request only follows a low-power state and lasts one cycle
  assert_wake_origin_R9: assert property (@(posedge clk) disable iff (!rstPinN)
    wakeReq |-> $past(inSleep || inClkStop));
  assert_wake_single_R9: assert property (@(posedge clk) disable iff (!rstPinN)
    wakeReq |=> !wakeReq);
endmodule

// File: tb/clkstop_ctrl_tb.sv
module clkstop_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstPinN, stbyPinN, sleepStb, swStandby, clkStopEn;
  logic [15:0] modStopMask, extStopMask, auxStopMask;
  logic        busCycleDone, nmiIn, intDisable, cpuMaskAll;
  logic [17:0] wakeSrc, xferRoute;
  logic        periphClkEn, busClkEn, ioClkEn, tmrClkEn, wdtClkEn, auxClkEn;
  logic        wakeReq, inSleep, inClkStop, inHwStby;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    string      tag;
    logic [9:0] exp;
  } item_t;
  item_t sb[$];

  // Output vector: {inSleep,inClkStop,inHwStby,periph,bus,io,tmr,wdt,aux,wakeReq}
  localparam logic [9:0] RUNV   = 10'b000_111111_0;
  localparam logic [9:0] WAKEV  = 10'b000_111111_1;
  localparam logic [9:0] SLPV   = 10'b100_111111_0;
  localparam logic [9:0] STOPV  = 10'b010_000010_0;
  localparam logic [9:0] STOPT  = 10'b010_000110_0;
  localparam logic [9:0] STOPA  = 10'b010_000011_0;
  localparam logic [9:0] HWV    = 10'b001_000000_0;

  always #10 clk = ~clk;

  clkstop_ctrl u_dut (
    .clk(clk), .rstPinN(rstPinN), .stbyPinN(stbyPinN), .sleepStb(sleepStb),
    .swStandby(swStandby), .clkStopEn(clkStopEn), .modStopMask(modStopMask),
    .extStopMask(extStopMask), .auxStopMask(auxStopMask),
    .busCycleDone(busCycleDone), .nmiIn(nmiIn), .wakeSrc(wakeSrc),
    .xferRoute(xferRoute), .intDisable(intDisable), .cpuMaskAll(cpuMaskAll),
    .periphClkEn(periphClkEn), .busClkEn(busClkEn), .ioClkEn(ioClkEn),
    .tmrClkEn(tmrClkEn), .wdtClkEn(wdtClkEn), .auxClkEn(auxClkEn),
    .wakeReq(wakeReq), .inSleep(inSleep), .inClkStop(inClkStop), .inHwStby(inHwStby)
  );

  // Monitor: after each edge, compare outputs against the next expected item.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        item_t it;
        logic [9:0] act;
        it  = sb.pop_front();
        act = {inSleep, inClkStop, inHwStby, periphClkEn, busClkEn, ioClkEn,
               tmrClkEn, wdtClkEn, auxClkEn, wakeReq};
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %b expected %b", it.tag, act, it.exp);
        end
      end
    end
  end

  // Driver: inputs already applied at a falling edge; expect result after next rise.
  task automatic step(input string tag, input logic [9:0] exp);
    item_t it;
    it.tag = tag;
    it.exp = exp;
    sb.push_back(it);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    sleepStb = 0; busCycleDone = 0; nmiIn = 0; wakeSrc = '0;
    xferRoute = '0; intDisable = 0; cpuMaskAll = 0;
  endtask

  task automatic armStop(input logic [15:0] m, input logic [15:0] a);
    clkStopEn = 1; swStandby = 0;
    modStopMask = m; extStopMask = 16'hFFFF; auxStopMask = a;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstPinN = 0; stbyPinN = 1; swStandby = 0; clkStopEn = 0;
    modStopMask = '0; extStopMask = '0; auxStopMask = '0;
    idle();
    @(negedge clk);
    step("R1 reset", RUNV);
    sleepStb = 1; clkStopEn = 1; modStopMask = 16'hFFFF; extStopMask = 16'hFFFF;
    step("R1 reset overrides strobe", RUNV);
    rstPinN = 1; idle();
    step("R1 run after reset", RUNV);

    // Eligible entry, deferred to bus-cycle end
    armStop(16'hFFFF, 16'hFFFF);
    sleepStb = 1;
    step("R3 strobe cycle unchanged", RUNV);
    sleepStb = 0;
    step("R3 pending waits for bus", RUNV);
    busCycleDone = 1;
    step("R4 stop entered", STOPV);
    busCycleDone = 0;
    step("R6 aux stopped when mask all ones", STOPV);

    // Qualification of non-NMI sources
    wakeSrc[3] = 1; intDisable = 1;
    step("R10 globally disabled", STOPV);
    intDisable = 0; cpuMaskAll = 1;
    step("R10 cpu mask", STOPV);
    cpuMaskAll = 0; xferRoute[3] = 1;
    step("R10 routed to transfer", STOPV);
    xferRoute[3] = 0;
    step("R9 irq3 wake", WAKEV);
    idle();
    step("R9 wake pulse one cycle", RUNV);

    // Timer kept running, NMI wake through disabled interrupts
    armStop(16'hFFFE, 16'hFFFF);
    sleepStb = 1;
    step("R3 strobe", RUNV);
    sleepStb = 0; busCycleDone = 1;
    step("R5 timer clock kept", STOPT);
    busCycleDone = 0; nmiIn = 1; intDisable = 1; cpuMaskAll = 1;
    step("R10 NMI wakes regardless", WAKEV);
    idle();
    step("R9 back to run", RUNV);

    // Aux group not all ones; wake from timer source
    armStop(16'hFFFF, 16'h7FFF);
    sleepStb = 1;
    step("R3 strobe", RUNV);
    sleepStb = 0; busCycleDone = 1;
    step("R6 aux clock kept", STOPA);
    busCycleDone = 0; wakeSrc[16] = 1;
    step("R9 timer wake", WAKEV);
    idle();
    step("R9 run", RUNV);

    // Ineligible: enable bit clear -> ordinary sleep
    armStop(16'hFFFF, 16'hFFFF); clkStopEn = 0;
    sleepStb = 1;
    step("R7 ordinary sleep (enable 0)", SLPV);
    sleepStb = 0; busCycleDone = 1;
    step("R7 sleep ignores bus end", SLPV);
    busCycleDone = 0; wakeSrc[17] = 1;
    step("R9 watchdog wake from sleep", WAKEV);
    idle();
    // Ineligible masks
    armStop(16'h7FFF, 16'hFFFF);
    sleepStb = 1;
    step("R2 bad first mask gives sleep", SLPV);
    sleepStb = 0; wakeSrc[0] = 1;
    step("R9 wake", WAKEV);
    idle();
    armStop(16'hFFFF, 16'hFFFF); extStopMask = 16'hFFFE;
    sleepStb = 1;
    step("R2 bad extended mask gives sleep", SLPV);
    sleepStb = 0; nmiIn = 1;
    step("R9 nmi wake", WAKEV);
    idle();

    // Software standby set: strobe ignored
    armStop(16'hFFFF, 16'hFFFF); swStandby = 1;
    sleepStb = 1;
    step("R8 strobe ignored", RUNV);
    sleepStb = 0; busCycleDone = 1;
    step("R8 still run", RUNV);
    idle(); swStandby = 0;

    // Pending entry cancelled by wake
    sleepStb = 1;
    step("R3 strobe", RUNV);
    sleepStb = 0; wakeSrc[0] = 1; busCycleDone = 1;
    step("R11 wake cancels pending", RUNV);
    wakeSrc[0] = 0;
    step("R11 later bus end has no effect", RUNV);
    idle();

    // Reset pin in clock-stop
    sleepStb = 1;
    step("R3 strobe", RUNV);
    sleepStb = 0; busCycleDone = 1;
    step("R4 stop", STOPV);
    busCycleDone = 0; rstPinN = 0;
    step("R1 reset leaves stop without wake", RUNV);
    rstPinN = 1;
    step("R1 run", RUNV);

    // Hardware standby
    sleepStb = 1;
    step("R3 strobe", RUNV);
    sleepStb = 0; busCycleDone = 1;
    step("R4 stop", STOPV);
    busCycleDone = 0; stbyPinN = 0;
    step("R12 standby from stop", HWV);
    rstPinN = 0;
    step("R12 standby beats reset", HWV);
    rstPinN = 1; stbyPinN = 1; nmiIn = 1;
    step("R12 stays without reset", HWV);
    nmiIn = 0; rstPinN = 0;
    step("R12 reset exits standby", RUNV);
    rstPinN = 1; stbyPinN = 0;
    step("R12 standby from run", HWV);
    stbyPinN = 1; rstPinN = 0;
    step("R1 reset exit", RUNV);
    rstPinN = 1;
    step("R1 run", RUNV);

    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule